// File: doc/BRIEF.md
# Two-Wire Half-Duplex Register Slave

This block is the device side of a serial port with two pins: a clock that the host always drives and a single data line that both ends share. Every transaction is 16 clocks long. The first bit sets the direction (1 for a write, 0 for a read). Seven address bits follow, most significant bit first, and then eight data bits, also most significant bit first. The host changes the data line on falling clock edges. The device samples it on rising clock edges. On a read, the device takes the line after the last address bit, shifts out the register contents and then gives the line back.

Behind the port sits a small register file. It holds a configuration register with soft-reset, power-down, shutter and forced-awake bits. It holds a read-only status register with a fixed identity code and an awake flag. It also holds two motion accumulators, Y and X. Motion deltas arrive on a parallel input port and are added with saturation. Each accumulator is cleared when it is read. A watchdog throws away any transaction that stalls partway, so that host and device fall back into step. Both pins pass through two-flop synchronizers into the system clock before any edge is detected.

Top module: `tw_reg_slave`

## Requirements
- R1: A write transaction sends 1, then seven address bits (MSB first), then eight data bits (MSB first). Addressed to 0x40, it stores the data bits at positions 6, 5 and 0. Bits 4 to 1 always read back as 0, and `cfg_o` shows the stored value.
- R2: A read transaction sends 0, then seven address bits. `sdio_oe` stays low up to the 8th rising clock edge and goes high after it. The register value then appears on `sdio_o` MSB first, one bit per falling edge, so that the host can sample it on rising edges 9 to 16.
- R3: After the 16th rising edge of a read, the device keeps driving D0. It releases the line (`sdio_oe` low) on the next falling clock edge.
- R4: If a transaction has not completed its 16th rising edge within `TIMEOUT_CYC` system clocks of its first rising edge, the partial transaction is discarded. The next edge then starts a new transaction.
- R5: A write to an address other than 0x40 changes no register and never raises `sdio_oe`. A read from an address other than 0x40 to 0x43 returns 0x00.
- R6: The configuration register resets to 0x00. Writing it with bit 7 set pulses `soft_rst_o` for one cycle and clears both motion accumulators. Bits 6, 5 and 0 of that write are still stored, and bit 7 always reads back as 0.
- R7: The status register at 0x41 reads as 0b010 in bits 7 to 5, zeros in bits 4 to 1, and `awake_i` in bit 0. It is 0x41 when awake.
- R8: Address 0x42 (Y) and address 0x43 (X) return the two's-complement sum of the `dy_i` or `dx_i` values presented with `mot_vld_i` since the last read of that register. A read clears the register.
- R9: Each motion accumulator saturates at +127 and at -128 instead of wrapping.
- R10: Motion that arrives after a motion register has been captured for a read, but while the read is still shifting out, is not lost. It appears in the next report.
- R11: While configuration bit 6 (power-down) is set, a write to 0x40 updates only bit 6.
- R12: While power-down is set, the watchdog does not abort a stalled transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sck_i | input | 1 | Serial clock from the host (asynchronous) |
| sdio_i | input | 1 | Shared data line as seen at the pad (asynchronous) |
| sdio_o | output | 1 | Data bit the device drives during a read |
| sdio_oe | output | 1 | Output enable for the data line |
| mot_vld_i | input | 1 | Motion deltas on `dx_i` and `dy_i` are valid this cycle |
| dx_i | input | 8 | X motion delta, two's complement |
| dy_i | input | 8 | Y motion delta, two's complement |
| awake_i | input | 1 | Awake flag that is reported in the status register |
| cfg_o | output | 8 | Current configuration register value |
| soft_rst_o | output | 1 | One-cycle pulse on a soft reset |

## Verification
The hardest cases to reach from the ports are the two watchdog cases. In each one, a transaction must be abandoned partway and the port must be shown to have recovered, or shown to have deliberately not recovered. To bring about the normal case, the bench sends five bits, parks the clock high for longer than the timeout and then does a full status read. That read returns the identity code only if the partial bits were thrown away. In power-down, the bench splits a configuration write into a 4-bit head and a 12-bit tail with a gap longer than the timeout in between. The read-back shows that the two halves were joined into one write.

// File: rtl/tw_pkg.sv
// Package: shared constants for the two-wire register slave.
// Assumes 7-bit addresses and 8-bit registers.
package tw_pkg;
    localparam int          ADDR_W    = 7;
    localparam int          DATA_W    = 8;
    localparam logic [6:0]  A_CFG     = 7'h40;
    localparam logic [6:0]  A_STAT    = 7'h41;
    localparam logic [6:0]  A_DY      = 7'h42;
    localparam logic [6:0]  A_DX      = 7'h43;
    localparam logic [7:0]  CFG_KEEP  = 8'h61;   // stored bits: power-down, shutter, awake
    localparam logic [7:0]  CFG_PD    = 8'h40;   // power-down bit
    localparam logic [2:0]  DEV_ID    = 3'b010;
endpackage

// File: rtl/tw_sync.sv
// Module: two-flop synchronizer for a vector of independent single-bit inputs.
// Assumes each bit is a slow level, so no bus coherence is needed.
module tw_sync #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] meta;

    // Two register stages per bit; reset to 1 (idle level of the lines).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= '1;
            q_o  <= '1;
        end else begin
            meta <= d_i;
            q_o  <= meta;
        end
    end
endmodule

// File: rtl/tw_acc.sv
// Module: saturating 8-bit two's-complement motion accumulator with clear.
// Assumes a clear and a new delta in the same cycle: the delta starts the next report.
module tw_acc (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr_i,
    input  logic       vld_i,
    input  logic [7:0] d_i,
    output logic [7:0] acc_o
);
    logic signed [8:0] sum;
    logic        [7:0] sat;

    // Widened sum and clamp to the 8-bit signed range.
    always_comb begin
        sum = $signed({acc_o[7], acc_o}) + $signed({d_i[7], d_i});
        if (sum > 9'sd127)
            sat = 8'h7F;
        else if (sum < -9'sd128)
            sat = 8'h80;
        else
            sat = sum[7:0];
    end

    // Accumulator register: clear-on-read keeps any delta arriving in that cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            acc_o <= '0;
        else if (clr_i)
            acc_o <= vld_i ? d_i : 8'h00;
        else if (vld_i)
            acc_o <= sat;
    end
endmodule

// File: rtl/tw_port.sv
// Module: serial transaction engine. Detects clock edges on the synchronized pins,
// shifts in the header and write data, shifts out read data and runs the stall watchdog.
// Assumes the serial clock half period is several system clocks long.
module tw_port #(
    parameter int TIMEOUT_CYC = 22_500_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sck_s,
    input  logic       sdio_s,
    input  logic       pd_i,
    input  logic [7:0] rd_data_i,
    output logic       rd_en_o,
    output logic       wr_en_o,
    output logic [6:0] addr_o,
    output logic [7:0] wdata_o,
    output logic       sdio_o,
    output logic       sdio_oe,
    output logic       sck_fall_o,
    output logic       hold_o,
    output logic       abort_o
);
    localparam int WW = $clog2(TIMEOUT_CYC + 1);

    logic          sck_q;
    logic          rise;
    logic [4:0]    bitcnt;
    logic [14:0]   shreg;
    logic [7:0]    tx;
    logic [WW-1:0] wd;
    logic          busy;

    assign rise       = sck_s & ~sck_q;
    assign sck_fall_o = ~sck_s & sck_q;
    assign busy       = (bitcnt != 5'd0);
    assign abort_o    = busy && !pd_i && (wd == WW'(TIMEOUT_CYC - 1));

    // Decode: a read is requested on the 8th rise, a write completes on the 16th.
    assign rd_en_o = rise && (bitcnt == 5'd7) && !shreg[6];
    assign wr_en_o = rise && (bitcnt == 5'd15) && shreg[14];
    assign addr_o  = (bitcnt == 5'd7) ? {shreg[5:0], sdio_s} : shreg[13:7];
    assign wdata_o = {shreg[6:0], sdio_s};
    assign sdio_o  = tx[7];

    // Edge-detect register for the synchronized clock.
    always_ff @(posedge clk) begin
        if (!rst_n) sck_q <= 1'b1;
        else        sck_q <= sck_s;
    end

    // Transaction state: bit counter, shifters, output enable, hold and watchdog.
    always_ff @(posedge clk) begin
        if (!rst_n || abort_o) begin
            bitcnt  <= '0;
            shreg   <= '0;
            tx      <= '0;
            sdio_oe <= 1'b0;
            hold_o  <= 1'b0;
            wd      <= '0;
        end else begin
            if (!busy)
                wd <= '0;
            else if (!pd_i)
                wd <= wd + 1'b1;
            if (rise) begin
                shreg  <= {shreg[13:0], sdio_s};
                bitcnt <= (bitcnt == 5'd15) ? 5'd0 : bitcnt + 5'd1;
                if (bitcnt == 5'd7 && !shreg[6]) begin
                    tx      <= rd_data_i;
                    sdio_oe <= 1'b1;
                end
                if (bitcnt == 5'd15) begin
                    wd <= '0;
                    if (sdio_oe) hold_o <= 1'b1;
                end
            end else if (sck_fall_o) begin
                if (hold_o) begin
                    sdio_oe <= 1'b0;
                    hold_o  <= 1'b0;
                end else if (sdio_oe && bitcnt >= 5'd9) begin
                    tx <= {tx[6:0], 1'b0};
                end
            end
        end
    end
endmodule

// File: rtl/tw_regs.sv
// Module: register file behind the port: configuration, status and two motion accumulators.
// Assumes rd_en and wr_en are single-cycle strobes with a valid address.
module tw_regs
    import tw_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rd_en_i,
    input  logic       wr_en_i,
    input  logic [6:0] addr_i,
    input  logic [7:0] wdata_i,
    input  logic       awake_i,
    input  logic       mot_vld_i,
    input  logic [7:0] dx_i,
    input  logic [7:0] dy_i,
    output logic [7:0] rd_data_o,
    output logic [7:0] cfg_o,
    output logic       soft_rst_o,
    output logic       clr_y_o,
    output logic [7:0] acc_y_o
);
    logic       cfg_hit;
    logic       srst_now;
    logic [1:0] clr;
    logic [7:0] din [2];
    logic [7:0] acc [2];

    assign cfg_hit  = wr_en_i && (addr_i == A_CFG);
    assign srst_now = cfg_hit && wdata_i[7] && !cfg_o[6];
    assign clr[0]   = srst_now || (rd_en_i && addr_i == A_DY);
    assign clr[1]   = srst_now || (rd_en_i && addr_i == A_DX);
    assign din[0]   = dy_i;
    assign din[1]   = dx_i;
    assign clr_y_o  = clr[0];
    assign acc_y_o  = acc[0];

    // One accumulator per axis: index 0 is Y, index 1 is X.
    for (genvar g = 0; g < 2; g++) begin : g_axis
        tw_acc u_acc (
            .clk   (clk),
            .rst_n (rst_n),
            .clr_i (clr[g]),
            .vld_i (mot_vld_i),
            .d_i   (din[g]),
            .acc_o (acc[g])
        );
    end

    // Configuration register with power-down write gating, plus the soft-reset pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_o      <= '0;
            soft_rst_o <= 1'b0;
        end else begin
            soft_rst_o <= srst_now;
            if (cfg_hit) begin
                if (cfg_o[6])
                    cfg_o <= (cfg_o & ~CFG_PD) | (wdata_i & CFG_PD);
                else
                    cfg_o <= wdata_i & CFG_KEEP;
            end
        end
    end

    // Read mux; unmapped addresses return zero.
    always_comb begin
        unique case (addr_i)
            A_CFG:   rd_data_o = cfg_o;
            A_STAT:  rd_data_o = {DEV_ID, 4'b0000, awake_i};
            A_DY:    rd_data_o = acc[0];
            A_DX:    rd_data_o = acc[1];
            default: rd_data_o = 8'h00;
        endcase
    end
endmodule

// File: rtl/tw_reg_slave.sv
// Module: top of the two-wire register slave. Synchronizes the pins, runs the
// transaction engine and holds the register file.
// Assumes the pad drives sdio_i with sdio_o whenever sdio_oe is high.
module tw_reg_slave #(
    parameter int TIMEOUT_CYC = 22_500_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sck_i,
    input  logic       sdio_i,
    output logic       sdio_o,
    output logic       sdio_oe,
    input  logic       mot_vld_i,
    input  logic [7:0] dx_i,
    input  logic [7:0] dy_i,
    input  logic       awake_i,
    output logic [7:0] cfg_o,
    output logic       soft_rst_o
);
    logic [1:0] pins_s;
    logic       rd_en, wr_en, sck_fall, rd_hold, wd_abort, clr_y;
    logic [6:0] addr;
    logic [7:0] wdata, rd_data, acc_y;

    tw_sync #(.W(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({sck_i, sdio_i}),
        .q_o   (pins_s)
    );

    tw_port #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_port (
        .clk        (clk),
        .rst_n      (rst_n),
        .sck_s      (pins_s[1]),
        .sdio_s     (pins_s[0]),
        .pd_i       (cfg_o[6]),
        .rd_data_i  (rd_data),
        .rd_en_o    (rd_en),
        .wr_en_o    (wr_en),
        .addr_o     (addr),
        .wdata_o    (wdata),
        .sdio_o     (sdio_o),
        .sdio_oe    (sdio_oe),
        .sck_fall_o (sck_fall),
        .hold_o     (rd_hold),
        .abort_o    (wd_abort)
    );

    tw_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_en_i    (rd_en),
        .wr_en_i    (wr_en),
        .addr_i     (addr),
        .wdata_i    (wdata),
        .awake_i    (awake_i),
        .mot_vld_i  (mot_vld_i),
        .dx_i       (dx_i),
        .dy_i       (dy_i),
        .rd_data_o  (rd_data),
        .cfg_o      (cfg_o),
        .soft_rst_o (soft_rst_o),
        .clr_y_o    (clr_y),
        .acc_y_o    (acc_y)
    );
endmodule

// File: rtl/tw_reg_slave_chk.sv
// Module: property checker for tw_reg_slave, attached by bind.
// Assumes synchronous active-low reset on rst_n.
module tw_reg_slave_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sdio_o,
    input logic       sdio_oe,
    input logic [7:0] cfg_o,
    input logic       soft_rst_o,
    input logic       sck_fall,
    input logic       rd_hold,
    input logic       wd_abort,
    input logic       clr_y,
    input logic       mot_vld_i,
    input logic [7:0] acc_y
);
    // Driven read data moves only on a detected falling clock edge.
    assert_data_steady_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sdio_oe && !sck_fall) |=> $stable(sdio_o));

    // The held D0 is released on the falling edge that follows the last rising edge.
    assert_release_on_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_hold && sck_fall) |=> !sdio_oe);

    // The soft-reset pulse lasts exactly one cycle.
    assert_srst_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst_o |=> !soft_rst_o);

    // Reading Y with no new motion leaves the accumulator at zero.
    assert_read_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_y && !mot_vld_i) |=> (acc_y == 8'h00));

    // The watchdog never fires while power-down is set.
    assert_no_abort_pd_R12: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_o[6] |-> !wd_abort);
endmodule

bind tw_reg_slave tw_reg_slave_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sdio_o     (sdio_o),
    .sdio_oe    (sdio_oe),
    .cfg_o      (cfg_o),
    .soft_rst_o (soft_rst_o),
    .sck_fall   (sck_fall),
    .rd_hold    (rd_hold),
    .wd_abort   (wd_abort),
    .clr_y      (clr_y),
    .mot_vld_i  (mot_vld_i),
    .acc_y      (acc_y)
);

// File: tb/tw_reg_slave_test.sv
// Scoreboard bench for tw_reg_slave: read tasks queue expected values,
// a monitor process compares them with captured serial data.
module tw_reg_slave_test;
    localparam int TMO = 600;
    localparam int H   = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sck = 1'b1;
    logic       host_d = 1'b1;
    logic       mot_vld = 1'b0;
    logic [7:0] dx = '0, dy = '0;
    logic       awake = 1'b1;
    logic       sdio_o, sdio_oe, soft_rst;
    logic [7:0] cfg;
    logic       line;
    logic       chk_rel = 1'b0;
    logic       done = 1'b0;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] exp_q [$];
    string      tag_q [$];
    logic [7:0] got_q [$];
    logic [7:0] mx = '0, my = '0;

    assign line = sdio_oe ? sdio_o : host_d;

    always #2 clk = ~clk;

    tw_reg_slave #(.TIMEOUT_CYC(TMO)) uut (
        .clk(clk), .rst_n(rst_n), .sck_i(sck), .sdio_i(line),
        .sdio_o(sdio_o), .sdio_oe(sdio_oe), .mot_vld_i(mot_vld),
        .dx_i(dx), .dy_i(dy), .awake_i(awake), .cfg_o(cfg), .soft_rst_o(soft_rst)
    );

    task automatic check(input logic [7:0] act, input logic [7:0] expv, input string tag);
        n_chk++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    function automatic logic [7:0] sadd(input logic [7:0] a, input logic [7:0] b);
        int s;
        s = int'($signed(a)) + int'($signed(b));
        if (s > 127) return 8'h7F;
        if (s < -128) return 8'h80;
        return 8'(s);
    endfunction

    task automatic mot(input logic [7:0] x, input logic [7:0] y);
        @(negedge clk);
        mot_vld = 1'b1; dx = x; dy = y;
        @(negedge clk);
        mot_vld = 1'b0;
        mx = sadd(mx, x); my = sadd(my, y);
    endtask

    task automatic bit_out(input logic b);
        sck = 1'b0; host_d = b;
        repeat (H) @(negedge clk);
        if (chk_rel) begin
            check({7'b0, sdio_oe}, 8'h00, "R3 release after fall");
            chk_rel = 1'b0;
        end
        sck = 1'b1;
        repeat (H) @(negedge clk);
    endtask

    task automatic gap();
        repeat (4 * H) @(negedge clk);
    endtask

    task automatic sp_write(input logic [6:0] a, input logic [7:0] d);
        bit_out(1'b1);
        for (int i = 6; i >= 0; i--) bit_out(a[i]);
        for (int i = 7; i >= 0; i--) bit_out(d[i]);
        gap();
    endtask

    // Read: header, then sample on each rise; optional motion injected mid data phase.
    task automatic sp_read(input logic [6:0] a, input bit inj, input logic [7:0] ix,
                           input logic [7:0] iy);
        logic [7:0] v;
        bit_out(1'b0);
        for (int i = 6; i >= 1; i--) bit_out(a[i]);
        sck = 1'b0; host_d = a[0];
        repeat (H) @(negedge clk);
        check({7'b0, sdio_oe}, 8'h00, "R2 no drive before 8th rise");
        sck = 1'b1;
        repeat (H) @(negedge clk);
        for (int i = 7; i >= 0; i--) begin
            sck = 1'b0;
            repeat (H) @(negedge clk);
            if (i == 7) check({7'b0, sdio_oe}, 8'h01, "R2 drive after 8th rise");
            if (i == 4 && inj) mot(ix, iy);
            v[i] = line;
            sck = 1'b1;
            repeat (H) @(negedge clk);
        end
        check({7'b0, sdio_oe}, 8'h01, "R3 D0 held after 16th rise");
        check({7'b0, line}, {7'b0, v[0]}, "R3 D0 value held");
        got_q.push_back(v);
        chk_rel = 1'b1;
        gap();
    endtask

    task automatic expect_rd(input logic [6:0] a, input logic [7:0] e, input string tag);
        exp_q.push_back(e); tag_q.push_back(tag);
        sp_read(a, 1'b0, 8'h00, 8'h00);
    endtask

    // Monitor: pops expected and captured values in order and compares them.
    initial begin
        forever begin
            wait (got_q.size() > 0);
            check(got_q.pop_front(), exp_q.pop_front(), tag_q.pop_front());
        end
    end

    // Watchdog: a hung run counts as one failure and still reports.
    initial begin
        repeat (150_000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: run did not complete");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check({7'b0, sdio_oe}, 8'h00, "R2 reset oe low");
        check(cfg, 8'h00, "R6 cfg_o reset value");

        expect_rd(7'h41, 8'h41, "R7 status awake");
        awake = 1'b0;
        expect_rd(7'h41, 8'h40, "R7 status asleep");
        awake = 1'b1;
        expect_rd(7'h40, 8'h00, "R6 config reset read");

        sp_write(7'h40, 8'h21);
        check(cfg, 8'h21, "R1 cfg_o after write");
        expect_rd(7'h40, 8'h21, "R1 config readback");
        sp_write(7'h40, 8'h3F);
        expect_rd(7'h40, 8'h21, "R1 reserved bits read zero");

        sp_write(7'h77, 8'h55);
        check({7'b0, sdio_oe}, 8'h00, "R5 unmapped write leaves line free");
        expect_rd(7'h77, 8'h00, "R5 unmapped read zero");
        expect_rd(7'h40, 8'h21, "R5 config untouched");

        mot(8'd5, 8'hFD);
        mot(8'd10, 8'd1);
        expect_rd(7'h42, my, "R8 Y sum"); my = 8'h00;
        expect_rd(7'h43, mx, "R8 X sum"); mx = 8'h00;
        expect_rd(7'h43, 8'h00, "R8 X cleared by read");

        mot(8'd100, 8'h9C);
        mot(8'd100, 8'h9C);
        expect_rd(7'h43, 8'h7F, "R9 X positive saturation"); mx = 8'h00;
        expect_rd(7'h42, 8'h80, "R9 Y negative saturation"); my = 8'h00;

        mot(8'd3, 8'd4);
        exp_q.push_back(8'd3); tag_q.push_back("R10 current report unaffected");
        mx = 8'h00;
        sp_read(7'h43, 1'b1, 8'd7, 8'hFF);
        expect_rd(7'h43, 8'd7, "R10 late motion in next report"); mx = 8'h00;
        expect_rd(7'h42, 8'd3, "R10 Y keeps both"); my = 8'h00;

        mot(8'd9, 8'd9);
        sp_write(7'h40, 8'hA1);
        expect_rd(7'h40, 8'h21, "R6 reset bit self-clears");
        expect_rd(7'h43, 8'h00, "R6 soft reset clears X");
        expect_rd(7'h42, 8'h00, "R6 soft reset clears Y");
        mx = 8'h00; my = 8'h00;

        bit_out(1'b0); bit_out(1'b1); bit_out(1'b0); bit_out(1'b0); bit_out(1'b0);
        repeat (TMO + 50) @(negedge clk);
        expect_rd(7'h41, 8'h41, "R4 watchdog resynchronizes");

        sp_write(7'h40, 8'h61);
        expect_rd(7'h40, 8'h61, "R11 enter power-down");
        sp_write(7'h40, 8'h40);
        expect_rd(7'h40, 8'h61, "R11 only bit 6 in power-down");
        bit_out(1'b1); bit_out(1'b1); bit_out(1'b0); bit_out(1'b0);
        repeat (TMO + 50) @(negedge clk);
        for (int i = 0; i < 12; i++) bit_out(1'b0);
        gap();
        expect_rd(7'h40, 8'h21, "R12 no watchdog abort in power-down");
        check(cfg, 8'h21, "R12 cfg_o after joined write");

        wait (got_q.size() == 0);
        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule